// File: doc/BRIEF.md
# Escaped extraction stream decoder

This block sits behind a switch's CPU extraction queue. The queue delivers a plain stream of 32-bit words, and the block rebuilds whole frames from it. Each frame opens with four header words. They arrive most-significant byte first, and the block turns each one into host byte order before it pulls out the fields. The fields are the frame length, the source port, a CPU queue mask, a tag-type bit and a 12-bit VLAN ID. The block holds this metadata and presents it for the whole frame. It is marked valid by a start flag on the first output beat.

Payload words leave on a valid/ready beat interface. Every beat but the last has all four bytes enabled. The last beat carries a byte-enable worked out from the header length. Control is carried in-band. A block of eight reserved word values, sharing the upper 29 bits of `CODE_BASE`, signals the following:
- end of frame, with the byte count of the final word;
- a pruned frame;
- abort;
- an empty queue read;
- an escape that makes the next word literal data.

The trailing four-byte FCS is removed unless `keep_fcs` is set. After any error the block pulses an error flag. It then swallows queue words for as long as the data-present input stays high.

Top module: `frame_extract_decoder`

## Requirements
- R1: After reset, `out_valid` and `out_err` are 0 and `in_ready` is 1.
- R2: Each header word is byte-reversed before decoding. In host order, word 2 bits 14:11 give `out_port`. Word 3 bits 27:20 give `out_cpuq`, bit 16 gives `out_tag` and bits 11:0 give `out_vid`. These values are present when `out_first` is 1, which happens on the first beat of the frame only, and they stay unchanged for the rest of the frame. Header word 0 is ignored.
- R3: `out_len` equals CELL_BYTES × W + B − 80. W is host-order header word 1 bits 14:7 and B is bits 20:15. With default parameters this is 60·W + B − 80.
- R4: Payload words appear on `out_data` unchanged and in order. Non-final beats have `out_be` = 4'hF and `out_last` = 0.
- R5: With `keep_fcs` = 0, the block emits exactly `out_len` − 4 bytes. The final beat has `out_last` = 1 and a byte-enable of n contiguous upper bits for n remaining bytes: 1→8, 2→C, 3→E, 4→F. Queue words beyond that point produce no beats.
- R6: `keep_fcs` is sampled on the fourth header word. When it is 1, the block emits `out_len` bytes.
- R7: Word values `CODE_BASE`+0..3 are end-of-frame codes, with low bits k giving the valid bytes of the final word (k = 0 means 4). `CODE_BASE`+4 marks a pruned frame with 4 valid bytes. The word after either code is the final word. If an escape precedes it, the final word is the word after the escape.
- R8: An escape code (`CODE_BASE`+6) makes the next word literal data, even if that word equals a reserved value. This applies in both the header and the payload.
- R9: The not-ready code (`CODE_BASE`+7) has no effect during the payload. In the header, that code and any end-of-frame, pruned or abort code is an error.
- R10: The abort code (`CODE_BASE`+5) in the payload is an error. An error raises `out_err` for one cycle, and no further beats of that frame follow.
- R11: After an error, while `data_present` is 1, `in_ready` stays 1 regardless of `out_ready`, and consumed words produce no beats. Once `data_present` is 0 the next word starts a new header.
- R12: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the output beat holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Queue word available |
| in_data | input | 32 | Queue word as read from the bus |
| in_ready | output | 1 | Queue word consumed this cycle when in_valid |
| data_present | input | 1 | Queue still holds words; used by the drain after an error |
| keep_fcs | input | 1 | 1: pass the trailing FCS bytes through |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 32 | Payload word, first byte in bits 31:24 |
| out_be | output | 4 | Byte enables, bit 3 for bits 31:24 |
| out_last | output | 1 | Final beat of the frame |
| out_first | output | 1 | First beat of the frame; metadata valid |
| out_len | output | 16 | Decoded frame length in bytes, FCS included |
| out_port | output | 4 | Source port |
| out_cpuq | output | 8 | CPU queue mask |
| out_tag | output | 1 | Tag type |
| out_vid | output | 12 | VLAN ID |
| out_err | output | 1 | One-cycle error pulse |

## Verification
A header counter that is off by one shifts every decoded field at once. The fault is visible on the first beat of that frame and on every frame after it. A literal flag left set or cleared at the wrong time shows up within one word. Either a reserved value leaks out as data, or a payload word vanishes and the final byte-enable moves. A wrong remaining-byte count shows on the last beat of the frame as a misplaced `out_last` or a wrong byte-enable pattern. A drain state that fails to release shows as a stuck frame that the following test frame exposes.

// File: rtl/fxd_pkg.sv
`timescale 1ns/1ps
package fxd_pkg;

    typedef enum logic [2:0] {
        K_DATA,
        K_EOF,
        K_PRUNED,
        K_ABORT,
        K_ESC,
        K_NOTRDY
    } word_kind_e;

    typedef enum logic [1:0] {
        S_HDR,
        S_PAY,
        S_FIN,
        S_DRAIN
    } dec_state_e;

    localparam int FCS_BYTES = 4;

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/fxd_word_class.sv
`timescale 1ns/1ps
module fxd_word_class
    import fxd_pkg::*;
#(
    parameter logic [31:0] CODE_BASE = 32'h8000_0000
) (
    input  logic [31:0] word,
    output word_kind_e  kind,
    output logic [2:0]  vbytes
);
    logic       is_code;
    logic [2:0] sel;

    assign is_code = (word[31:3] == CODE_BASE[31:3]);
    assign sel     = word[2:0];

    always_comb begin
        kind = K_DATA;
        if (is_code) begin
            unique case (sel)
                3'd0, 3'd1, 3'd2, 3'd3: kind = K_EOF;
                3'd4:                   kind = K_PRUNED;
                3'd5:                   kind = K_ABORT;
                3'd6:                   kind = K_ESC;
                default:                kind = K_NOTRDY;
            endcase
        end
    end

    // low two bits give the byte count of the final word, zero meaning all four
    assign vbytes = (sel[1:0] == 2'd0) ? 3'd4 : {1'b0, sel[1:0]};

endmodule

// File: rtl/fxd_hdr_fields.sv
`timescale 1ns/1ps
module fxd_hdr_fields
    import fxd_pkg::*;
#(
    parameter int CELL_BYTES = 60,
    parameter int LEN_OFFSET = 80,
    parameter int LEN_W      = 16
) (
    input  logic [31:0]      raw,
    output logic [LEN_W-1:0] len,
    output logic [3:0]       port,
    output logic [7:0]       cpuq,
    output logic             tag,
    output logic [11:0]      vid
);
    logic [31:0] h;
    logic [7:0]  word_cnt;
    logic [5:0]  tail_cnt;
    logic        unused_top;

    assign h        = swap_bytes(raw);
    assign word_cnt = h[14:7];
    assign tail_cnt = h[20:15];

    assign len  = LEN_W'(CELL_BYTES) * LEN_W'(word_cnt) + LEN_W'(tail_cnt)
                - LEN_W'(LEN_OFFSET);
    assign port = h[14:11];
    assign cpuq = h[27:20];
    assign tag  = h[16];
    assign vid  = h[11:0];

    assign unused_top = ^h[31:28];

endmodule

// File: rtl/fxd_beat_shape.sv
`timescale 1ns/1ps
module fxd_beat_shape #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] rem,
    input  logic [2:0]       avail,
    input  logic             force_last,
    output logic [3:0]       be,
    output logic [2:0]       take,
    output logic             last
);
    logic short_rem;

    assign short_rem = (rem < LEN_W'(avail));
    assign take      = short_rem ? rem[2:0] : avail;
    assign last      = force_last || (rem <= LEN_W'(avail));

    always_comb begin
        unique case (take)
            3'd1:    be = 4'b1000;
            3'd2:    be = 4'b1100;
            3'd3:    be = 4'b1110;
            default: be = 4'b1111;
        endcase
    end

endmodule

// File: rtl/frame_extract_decoder.sv
`timescale 1ns/1ps
module frame_extract_decoder
    import fxd_pkg::*;
#(
    parameter int          CELL_BYTES = 60,
    parameter int          LEN_OFFSET = 80,
    parameter int          LEN_W      = 16,
    parameter logic [31:0] CODE_BASE  = 32'h8000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    output logic             in_ready,
    input  logic             data_present,
    input  logic             keep_fcs,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_data,
    output logic [3:0]       out_be,
    output logic             out_last,
    output logic             out_first,
    output logic [LEN_W-1:0] out_len,
    output logic [3:0]       out_port,
    output logic [7:0]       out_cpuq,
    output logic             out_tag,
    output logic [11:0]      out_vid,
    output logic             out_err
);
    localparam int HDR_WORDS = 4;
    localparam int HCNT_W    = $clog2(HDR_WORDS);

    typedef struct packed {
        dec_state_e         st;
        logic [HCNT_W-1:0]  hcnt;
        logic               lit;
        logic [2:0]         fin_n;
        logic [LEN_W-1:0]   rem;
        logic               first_pend;
        logic [LEN_W-1:0]   len;
        logic [3:0]         port;
        logic [7:0]         cpuq;
        logic               tag;
        logic [11:0]        vid;
        logic               ov;
        logic [31:0]        od;
        logic [3:0]         obe;
        logic               olast;
        logic               ofirst;
        logic               err;
    } regs_t;

    regs_t q, d;

    word_kind_e       kind;
    logic [2:0]       vbytes;
    logic [LEN_W-1:0] f_len;
    logic [3:0]       f_port;
    logic [7:0]       f_cpuq;
    logic             f_tag;
    logic [11:0]      f_vid;
    logic [3:0]       sh_be;
    logic [2:0]       sh_take;
    logic             sh_last;
    logic             in_fin;
    logic             accept;
    logic             emit;
    logic             err_hit;

    fxd_word_class #(.CODE_BASE(CODE_BASE)) u_class (
        .word   (in_data),
        .kind   (kind),
        .vbytes (vbytes)
    );

    fxd_hdr_fields #(
        .CELL_BYTES (CELL_BYTES),
        .LEN_OFFSET (LEN_OFFSET),
        .LEN_W      (LEN_W)
    ) u_hdr (
        .raw  (in_data),
        .len  (f_len),
        .port (f_port),
        .cpuq (f_cpuq),
        .tag  (f_tag),
        .vid  (f_vid)
    );

    assign in_fin = (q.st == S_FIN);

    fxd_beat_shape #(.LEN_W(LEN_W)) u_shape (
        .rem        (q.rem),
        .avail      (in_fin ? q.fin_n : 3'd4),
        .force_last (in_fin),
        .be         (sh_be),
        .take       (sh_take),
        .last       (sh_last)
    );

    // drain ignores the output side; otherwise a word is taken only if its beat has room
    assign in_ready = (q.st == S_DRAIN) ? 1'b1 : (!q.ov || out_ready);
    assign accept   = in_valid && in_ready;

    always_comb begin
        d       = q;
        d.err   = 1'b0;
        emit    = 1'b0;
        err_hit = 1'b0;

        if (q.ov && out_ready) d.ov = 1'b0;

        if (q.st == S_DRAIN && !data_present) begin
            d.st   = S_HDR;
            d.hcnt = '0;
        end

        if (accept) begin
            unique case (q.st)
                S_HDR: begin
                    if (q.lit || kind == K_DATA) begin
                        d.lit  = 1'b0;
                        d.hcnt = HCNT_W'(q.hcnt + 1'b1);
                        if (q.hcnt == HCNT_W'(1)) d.len  = f_len;
                        if (q.hcnt == HCNT_W'(2)) d.port = f_port;
                        if (q.hcnt == HCNT_W'(HDR_WORDS - 1)) begin
                            d.cpuq       = f_cpuq;
                            d.tag        = f_tag;
                            d.vid        = f_vid;
                            d.rem        = keep_fcs ? q.len : q.len - LEN_W'(FCS_BYTES);
                            d.first_pend = 1'b1;
                            d.hcnt       = '0;
                            d.st         = S_PAY;
                        end
                    end else if (kind == K_ESC) begin
                        d.lit = 1'b1;
                    end else begin
                        err_hit = 1'b1;
                    end
                end
                S_PAY: begin
                    if (q.lit || kind == K_DATA) begin
                        d.lit = 1'b0;
                        emit  = 1'b1;
                    end else if (kind == K_ESC) begin
                        d.lit = 1'b1;
                    end else if (kind == K_ABORT) begin
                        err_hit = 1'b1;
                    end else if (kind == K_EOF || kind == K_PRUNED) begin
                        d.fin_n = vbytes;
                        d.st    = S_FIN;
                    end
                end
                S_FIN: begin
                    if (!q.lit && kind == K_ESC) begin
                        d.lit = 1'b1;
                    end else begin
                        d.lit  = 1'b0;
                        emit   = 1'b1;
                        d.st   = S_HDR;
                        d.hcnt = '0;
                    end
                end
                default: ;
            endcase
        end

        // once the byte budget is spent, later words are consumed silently
        if (emit && q.rem != '0) begin
            d.ov         = 1'b1;
            d.od         = in_data;
            d.obe        = sh_be;
            d.olast      = sh_last;
            d.ofirst     = q.first_pend;
            d.first_pend = 1'b0;
            d.rem        = q.rem - LEN_W'(sh_take);
        end

        if (err_hit) begin
            d.err        = 1'b1;
            d.st         = data_present ? S_DRAIN : S_HDR;
            d.hcnt       = '0;
            d.lit        = 1'b0;
            d.rem        = '0;
            d.first_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ov;
    assign out_data  = q.od;
    assign out_be    = q.obe;
    assign out_last  = q.olast;
    assign out_first = q.ofirst;
    assign out_len   = q.len;
    assign out_port  = q.port;
    assign out_cpuq  = q.cpuq;
    assign out_tag   = q.tag;
    assign out_vid   = q.vid;
    assign out_err   = q.err;

    a_r12_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_be) && $stable(out_last));

    a_r12_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    a_r10_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> !out_valid);

    a_r5_be_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_be == 4'b1000 || out_be == 4'b1100
                       || out_be == 4'b1110 || out_be == 4'b1111));

    a_r4_full_mid_beat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |-> out_be == 4'b1111);

    a_r2_meta_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_first |-> $stable(out_port) && $stable(out_cpuq)
                                    && $stable(out_tag) && $stable(out_vid));

endmodule

// File: tb/frame_extract_decoder_tb.sv
`timescale 1ns/1ps
module frame_extract_decoder_tb;

    localparam logic [31:0] BASE     = 32'h8000_0000;
    localparam logic [31:0] C_EOF0   = BASE + 32'd0;
    localparam logic [31:0] C_EOF2   = BASE + 32'd2;
    localparam logic [31:0] C_EOF3   = BASE + 32'd3;
    localparam logic [31:0] C_PRUNED = BASE + 32'd4;
    localparam logic [31:0] C_ABORT  = BASE + 32'd5;
    localparam logic [31:0] C_ESC    = BASE + 32'd6;
    localparam logic [31:0] C_NOTRDY = BASE + 32'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        data_present = 1'b0;
    logic        keep_fcs = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_be;
    logic        out_last;
    logic        out_first;
    logic [15:0] out_len;
    logic [3:0]  out_port;
    logic [7:0]  out_cpuq;
    logic        out_tag;
    logic [11:0] out_vid;
    logic        out_err;

    frame_extract_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .data_present(data_present), .keep_fcs(keep_fcs),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_be(out_be), .out_last(out_last), .out_first(out_first),
        .out_len(out_len), .out_port(out_port), .out_cpuq(out_cpuq),
        .out_tag(out_tag), .out_vid(out_vid), .out_err(out_err)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] pay [0:31];
    logic [31:0] cap_d [0:63];
    logic [3:0]  cap_be [0:63];
    logic        cap_last [0:63];
    logic        cap_first [0:63];
    int          cap_n = 0;
    int          err_n = 0;
    logic [15:0] m_len;
    logic [3:0]  m_port;
    logic [7:0]  m_cpuq;
    logic        m_tag;
    logic [11:0] m_vid;

    // capture beats well after the falling edge, once all bench drives have settled
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready && cap_n < 64) begin
            cap_d[cap_n]     = out_data;
            cap_be[cap_n]    = out_be;
            cap_last[cap_n]  = out_last;
            cap_first[cap_n] = out_first;
            if (out_first) begin
                m_len = out_len; m_port = out_port; m_cpuq = out_cpuq;
                m_tag = out_tag; m_vid = out_vid;
            end
            cap_n++;
        end
        if (rst_n && out_err) err_n++;
    end

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic bit is_code(input logic [31:0] w);
        return w[31:3] == BASE[31:3];
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic init_pay();
        for (int i = 0; i < 32; i++) pay[i] = 32'h1100_0000 + i * 32'h0001_0203;
    endtask

    task automatic clear_cap();
        cap_n = 0;
        err_n = 0;
    endtask

    task automatic push(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [3:0] port, input logic [7:0] cpuq,
                            input logic tag, input logic [11:0] vid,
                            input logic [7:0] wc, input logic [5:0] lc,
                            input bit hdr_esc);
        logic [31:0] hw [0:3];
        hw[0] = 32'h0;
        hw[1] = {11'b0, lc, wc, 7'b0};
        hw[2] = {17'b0, port, 11'b0};
        hw[3] = {4'b0, cpuq, 3'b0, tag, 4'b0, vid};
        for (int h = 0; h < 4; h++) begin
            if (hdr_esc && h == 2) push(C_ESC);
            push(rev(hw[h]));
        end
    endtask

    task automatic send_body(input int first, input int nfull,
                             input logic [31:0] eof, input int nr_at);
        for (int i = first; i < nfull; i++) begin
            if (i == nr_at) push(C_NOTRDY);
            if (is_code(pay[i])) push(C_ESC);
            push(pay[i]);
        end
        push(eof);
        if (is_code(pay[nfull])) push(C_ESC);
        push(pay[nfull]);
        idle(3);
    endtask

    task automatic check_frame(input string req, input int nb, input logic [3:0] last_be);
        chk({req, " beat count"}, cap_n, nb);
        for (int i = 0; i < nb && i < cap_n; i++) begin
            chk({req, " data"}, cap_d[i], pay[i]);
            chk({req, " be"}, {28'b0, cap_be[i]}, (i == nb - 1) ? {28'b0, last_be} : 32'hF);
            chk({req, " last"}, {31'b0, cap_last[i]}, (i == nb - 1) ? 32'd1 : 32'd0);
            chk({req, " first"}, {31'b0, cap_first[i]}, (i == 0) ? 32'd1 : 32'd0);
        end
    endtask

    task automatic frame_a(input bit keep, input int nr_at, input bit hdr_esc);
        keep_fcs = keep;
        send_hdr(4'h3, 8'h12, 1'b0, 12'h064, 8'd2, 6'd26, hdr_esc);
        send_body(0, 16, C_EOF2, nr_at);
    endtask

    task automatic t_reset();
        chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 out_err", {31'b0, out_err}, 32'd0);
    endtask

    task automatic t_strip();
        clear_cap();
        frame_a(1'b0, -1, 1'b0);
        check_frame("R5 R4 strip 66B", 16, 4'hC);
        chk("R3 len", {16'b0, m_len}, 32'd66);
        chk("R2 port", {28'b0, m_port}, 32'h3);
        chk("R2 cpuq", {24'b0, m_cpuq}, 32'h12);
        chk("R2 tag", {31'b0, m_tag}, 32'd0);
        chk("R2 vid", {20'b0, m_vid}, 32'h064);
    endtask

    task automatic t_keep();
        clear_cap();
        frame_a(1'b1, -1, 1'b0);
        check_frame("R6 R7 keep EOF2", 17, 4'hC);
    endtask

    task automatic t_eof_kinds();
        clear_cap();
        keep_fcs = 1'b1;
        send_hdr(4'h1, 8'h01, 1'b0, 12'h001, 8'd2, 6'd24, 1'b0);
        send_body(0, 15, C_EOF0, -1);
        check_frame("R7 EOF0 four bytes", 16, 4'hF);
        clear_cap();
        send_hdr(4'h1, 8'h01, 1'b0, 12'h001, 8'd2, 6'd23, 1'b0);
        send_body(0, 15, C_EOF3, -1);
        check_frame("R7 EOF3 three bytes", 16, 4'hE);
        clear_cap();
        send_hdr(4'h1, 8'h01, 1'b0, 12'h001, 8'd2, 6'd24, 1'b0);
        send_body(0, 15, C_PRUNED, -1);
        check_frame("R7 pruned", 16, 4'hF);
        chk("R3 len 64", {16'b0, m_len}, 32'd64);
    endtask

    task automatic t_escape();
        clear_cap();
        pay[3]  = C_ABORT;
        pay[16] = C_NOTRDY;
        frame_a(1'b1, -1, 1'b1);
        check_frame("R8 escaped literals", 17, 4'hC);
        chk("R8 header after escape port", {28'b0, m_port}, 32'h3);
        chk("R8 error count", err_n, 0);
        init_pay();
    endtask

    task automatic t_notrdy_pay();
        clear_cap();
        frame_a(1'b0, 5, 1'b0);
        check_frame("R9 not-ready in payload", 16, 4'hC);
    endtask

    task automatic t_notrdy_hdr();
        clear_cap();
        data_present = 1'b0;
        push(32'h0);
        push(C_NOTRDY);
        idle(3);
        chk("R9 header not-ready err", err_n, 1);
        chk("R9 header not-ready no beats", cap_n, 0);
        clear_cap();
        frame_a(1'b0, -1, 1'b0);
        check_frame("R9 recovery frame", 16, 4'hC);
    endtask

    task automatic t_abort_drain();
        clear_cap();
        data_present = 1'b1;
        keep_fcs = 1'b0;
        send_hdr(4'h3, 8'h12, 1'b0, 12'h064, 8'd2, 6'd26, 1'b0);
        for (int i = 0; i < 3; i++) push(pay[i]);
        push(C_ABORT);
        idle(3);
        chk("R10 abort err pulse", err_n, 1);
        chk("R10 beats before abort", cap_n, 3);
        chk("R10 no last before abort", {31'b0, cap_last[2]}, 32'd0);
        out_ready = 1'b0;
        #1;
        chk("R11 drain ignores out_ready", {31'b0, in_ready}, 32'd1);
        for (int i = 0; i < 5; i++) push(32'h2200_0000 + i);
        idle(2);
        chk("R11 drained words no beats", {31'b0, out_valid}, 32'd0);
        out_ready = 1'b1;
        data_present = 1'b0;
        idle(3);
        chk("R11 drained words not captured", cap_n, 3);
        clear_cap();
        frame_a(1'b0, -1, 1'b0);
        check_frame("R11 frame after drain", 16, 4'hC);
    endtask

    task automatic t_backpressure();
        logic [31:0] held;
        clear_cap();
        keep_fcs = 1'b0;
        send_hdr(4'h3, 8'h12, 1'b0, 12'h064, 8'd2, 6'd26, 1'b0);
        out_ready = 1'b0;
        push(pay[0]);
        #1;
        held = out_data;
        chk("R12 beat valid", {31'b0, out_valid}, 32'd1);
        chk("R12 in_ready low", {31'b0, in_ready}, 32'd0);
        repeat (3) @(negedge clk);
        #1;
        chk("R12 still valid", {31'b0, out_valid}, 32'd1);
        chk("R12 data held", out_data, held);
        chk("R12 data value", held, pay[0]);
        out_ready = 1'b1;
        send_body(1, 16, C_EOF2, -1);
        check_frame("R12 frame after stall", 16, 4'hC);
    endtask

    task automatic t_meta_edges();
        clear_cap();
        keep_fcs = 1'b0;
        send_hdr(4'hF, 8'hFF, 1'b1, 12'hFFF, 8'd1, 6'd36, 1'b0);
        send_body(0, 3, C_EOF0, -1);
        check_frame("R5 short frame", 3, 4'hF);
        chk("R3 len 16", {16'b0, m_len}, 32'd16);
        chk("R2 port F", {28'b0, m_port}, 32'hF);
        chk("R2 cpuq FF", {24'b0, m_cpuq}, 32'hFF);
        chk("R2 tag 1", {31'b0, m_tag}, 32'd1);
        chk("R2 vid FFF", {20'b0, m_vid}, 32'hFFF);
        clear_cap();
        send_hdr(4'hA, 8'h5C, 1'b1, 12'hABC, 8'd2, 6'd21, 1'b0);
        send_body(0, 15, C_EOF0, -1);
        check_frame("R5 one byte last", 15, 4'h8);
        chk("R2 vid ABC", {20'b0, m_vid}, 32'hABC);
        chk("R2 cpuq 5C", {24'b0, m_cpuq}, 32'h5C);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        init_pay();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_strip();
        t_keep();
        t_eof_kinds();
        t_escape();
        t_notrdy_pay();
        t_notrdy_hdr();
        t_abort_drain();
        t_backpressure();
        t_meta_edges();
        finish_run();
    end

endmodule